// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the serial front end of a multi-channel DAC. A host sends 32-bit words over three wires: an active-low frame select, a serial clock and a data line. The block samples the data line on each falling edge of the serial clock while the frame select is low, most significant bit first. When the 32nd falling edge of a frame has arrived, it presents a 4-bit command, a 4-bit channel address and a data code together with a one-cycle valid strobe. Downstream logic decodes the command and updates the DAC registers.

All three serial inputs pass through two-flop synchronizers into a faster system clock, and serial clock edges are detected in that domain. If the frame select rises before the 32nd falling edge, the partial word is thrown away. The shift state is cleared, no strobe is produced and the outputs keep their previous values. The code width (12, 14 or 16 bits) is a parameter. The code is the most significant part of the 20-bit data field and comes out right-aligned on a 16-bit port with zeros above it.

Top module: `dac_frame_rx`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o is 0 and cmd_o, addr_o and code_o are 0.
- R2: Serial bits arrive MSB first (frame bit 31 first, bit 0 last). cmd_o takes frame bits 27:24 and addr_o takes frame bits 23:20.
- R3: code_o[CODE_BITS-1:0] takes frame bits 19 down to 20-CODE_BITS. Bits 15:CODE_BITS of code_o are 0. The remaining low bits of the frame are ignored.
- R4: Each frame that reaches 32 falling edges with the select held low gives exactly one valid_o pulse, one system cycle long.
- R5: If the select rises after fewer than 32 falling edges, no valid_o pulse is produced and the outputs do not change.
- R6: After an aborted frame, the next frame is decoded exactly as if the aborted frame had never been sent.
- R7: Falling edges of the serial clock while the select is high have no effect on the outputs or on the next frame.
- R8: Falling edges after the 32nd in the same select-low period are ignored, and no second strobe is issued.
- R9: cmd_o, addr_o and code_o change only in the cycle in which valid_o is 1, and otherwise hold their values.
- R10: Frame bits 31:28 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, data is sampled on its falling edge |
| sdat_i | input | 1 | Serial data, MSB first |
| valid_o | output | 1 | One-cycle strobe for a complete frame |
| cmd_o | output | 4 | Command field of the last valid frame |
| addr_o | output | 4 | Channel address of the last valid frame |
| code_o | output | 16 | Data code, right-aligned and zero-extended |

## Verification
The bench builds two copies of the block that share the same serial wires: one with CODE_BITS=16 and one with CODE_BITS=12. Every frame is therefore checked against two different code slices and two padding widths at once. The 16-bit copy exposes errors in the left-justified bit positions. The 12-bit copy exposes errors in the zero-extension and in dropping the eight padding bits. Abort points at 10 and 31 edges, select-high clock activity and overrun edges are applied to both copies at the same time.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CMD_W      = 4;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 20;  // data field width in the frame
  localparam int CODE_PORT  = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift
  import dac_rx_pkg::*;
#(
  parameter int CODE_BITS = 16,
  localparam int PAD_BITS = DATA_W - CODE_BITS,
  localparam int KEEP_W   = CMD_W + ADDR_W + CODE_BITS,
  localparam int SHIFT_N  = FRAME_BITS - PAD_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_s_i,   // synchronized, active high = idle
  input  logic              sclk_s_i,
  input  logic              sdat_s_i,
  output logic              done_o,
  output logic [KEEP_W-1:0] frame_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [KEEP_W-1:0] sreg_q;
  logic              sclk_q;
  logic              fall;

  assign fall = sclk_q & ~sclk_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sreg_q <= '0;
      sclk_q <= 1'b1;
      done_o <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      done_o <= 1'b0;
      if (sel_s_i) begin
        cnt_q  <= '0;
        sreg_q <= '0;
      end else if (fall && cnt_q < CNT_W'(FRAME_BITS)) begin
        cnt_q <= cnt_q + 1'b1;
        // padding bits are counted but never stored
        if (cnt_q < CNT_W'(SHIFT_N)) sreg_q <= {sreg_q[KEEP_W-2:0], sdat_s_i};
        if (cnt_q == CNT_W'(FRAME_BITS-1)) done_o <= 1'b1;
      end
    end
  end

  assign frame_o = sreg_q;

  // R8
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS));
  // R5
  abort_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s_i |=> (cnt_q == '0) && !done_o);
  // R7
  idle_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!sel_s_i));
  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dac_rx_extract.sv
module dac_rx_extract
  import dac_rx_pkg::*;
#(
  parameter int CODE_BITS = 16,
  localparam int KEEP_W   = CMD_W + ADDR_W + CODE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [KEEP_W-1:0]    frame_i,
  output logic                 valid_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [CODE_PORT-1:0] code_o
);
  logic [CODE_PORT-1:0] code_d;

  always_comb begin
    code_d = '0;
    code_d[CODE_BITS-1:0] = frame_i[CODE_BITS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cmd_o   <= '0;
      addr_o  <= '0;
      code_o  <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        cmd_o  <= frame_i[KEEP_W-1 -: CMD_W];
        addr_o <= frame_i[KEEP_W-CMD_W-1 -: ADDR_W];
        code_o <= code_d;
      end
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R4
  valid_follows_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(done_i));
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dac_rx_pkg::*;
#(
  parameter int CODE_BITS = 16,
  localparam int KEEP_W   = CMD_W + ADDR_W + CODE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_ni,
  input  logic                 sclk_i,
  input  logic                 sdat_i,
  output logic                 valid_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [CODE_PORT-1:0] code_o
);
  if (CODE_BITS != 12 && CODE_BITS != 14 && CODE_BITS != 16) begin : g_bad_code_bits
    $error("CODE_BITS must be 12, 14 or 16");
  end

  logic [2:0]        pins_s;
  logic              done;
  logic [KEEP_W-1:0] frame;

  dac_rx_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdat_i, sclk_i, sel_ni}),
    .sync_o  (pins_s)
  );

  dac_rx_shift #(.CODE_BITS(CODE_BITS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_s_i  (pins_s[0]),
    .sclk_s_i (pins_s[1]),
    .sdat_s_i (pins_s[2]),
    .done_o   (done),
    .frame_o  (frame)
  );

  dac_rx_extract #(.CODE_BITS(CODE_BITS)) u_extract (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .frame_i (frame),
    .valid_o (valid_o),
    .cmd_o   (cmd_o),
    .addr_o  (addr_o),
    .code_o  (code_o)
  );

  // R9
  hold_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({cmd_o, addr_o, code_o}));
  // R3
  code_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o >> CODE_BITS) == '0);
endmodule

// File: tb/dac_frame_rx_tb_top.sv
module dac_frame_rx_tb_top;
  localparam int HALF = 6;  // system cycles per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, sdat = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        v16, v12;
  logic [3:0]  c16, a16, c12, a12;
  logic [15:0] d16, d12;

  dac_frame_rx #(.CODE_BITS(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .sdat_i(sdat),
    .valid_o(v16), .cmd_o(c16), .addr_o(a16), .code_o(d16));
  dac_frame_rx #(.CODE_BITS(12)) dut12_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .sdat_i(sdat),
    .valid_o(v12), .cmd_o(c12), .addr_o(a12), .code_o(d12));

  int errors = 0, checks = 0;
  string cur_req = "R1";
  logic [23:0] q16[$], q12[$];
  logic [23:0] last16 = '0, last12 = '0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_frame(input logic [31:0] f);
    q16.push_back({f[27:24], f[23:20], f[19:4]});
    q12.push_back({f[27:24], f[23:20], 4'h0, f[19:8]});
  endtask

  task automatic send(input logic [31:0] f, input int nb, input int extra);
    sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nb + extra; i++) begin
      sdat = (i < 32) ? f[31-i] : i[0];
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  // monitors
  always @(negedge clk) if (rst_n && v16) begin
    if (q16.size() == 0) chk(0, {cur_req, " unexpected strobe w16"}, {c16, a16, d16}, last16);
    else begin
      last16 = q16.pop_front();
      chk({c16, a16, d16} == last16, {cur_req, " frame w16"}, {c16, a16, d16}, last16);
    end
  end
  always @(negedge clk) if (rst_n && v12) begin
    if (q12.size() == 0) chk(0, {cur_req, " unexpected strobe w12"}, {c12, a12, d12}, last12);
    else begin
      last12 = q12.pop_front();
      chk({c12, a12, d12} == last12, {cur_req, " frame w12"}, {c12, a12, d12}, last12);
    end
  end

  task automatic hold_check(input string req);
    chk({c16, a16, d16} == last16, {req, " hold w16"}, {c16, a16, d16}, last16);
    chk({c12, a12, d12} == last12, {req, " hold w12"}, {c12, a12, d12}, last12);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", '0, '1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({v16, c16, a16, d16} == '0, "R1 in reset", {c16, a16, d16}, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({v16, v12, c12, a12, d12} == '0, "R1 after reset", {c12, a12, d12}, '0);

    cur_req = "R2 R3";
    expect_frame(32'h0A3B_EEFF);
    send(32'h0A3B_EEFF, 32, 0);
    expect_frame(32'h5C61_2345);
    send(32'h5C61_2345, 32, 0);

    cur_req = "R10";  // top nibble differs, outputs must match previous
    expect_frame(32'hFC61_2345);
    send(32'hFC61_2345, 32, 0);

    cur_req = "R5";
    send(32'h0123_4567, 10, 0);
    hold_check("R5 R9 abort10");
    send(32'h0F9E_DCBA, 31, 0);
    hold_check("R5 R9 abort31");

    cur_req = "R6";
    expect_frame(32'h0795_A5A5);
    send(32'h0795_A5A5, 32, 0);

    cur_req = "R7";
    for (int i = 0; i < 8; i++) begin
      sdat = i[0];
      repeat (HALF) @(negedge clk); sclk = 1'b0;
      repeat (HALF) @(negedge clk); sclk = 1'b1;
    end
    repeat (4*HALF) @(negedge clk);
    hold_check("R7 idle edges");
    expect_frame(32'h0A12_3456);
    send(32'h0A12_3456, 32, 0);

    cur_req = "R8";
    expect_frame(32'h0B4C_0FF0);
    send(32'h0B4C_0FF0, 32, 5);
    hold_check("R8 overrun");

    cur_req = "R3 R4 extremes";
    expect_frame(32'hFFFF_FFFF);
    send(32'hFFFF_FFFF, 32, 0);
    expect_frame(32'h0000_0000);
    send(32'h0000_0000, 32, 0);

    repeat (20) @(negedge clk);
    chk(q16.size() == 0, "R4 missing strobe w16", 24'(q16.size()), '0);
    chk(q12.size() == 0, "R4 missing strobe w12", 24'(q12.size()), '0);
    summary();
  end
endmodule